// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block sits behind a simple memory bus and behaves like the command interpreter of a parallel NOR flash. Every bus write is interpreted either as a command byte or as a data word. Which one depends on the command now pending and on whether that command is still waiting for its second bus cycle. Every bus read returns one of four things, chosen by the pending command: array contents, the 8-bit status register, a device identifier word, or one byte of a computed query table.

The array is a small synchronous word memory with one blank flag per word. A sector erase clears the flags of the whole sector in a single cycle, and a blank word reads as all ones. A read-only input blocks changes to the array and reports the blocked attempt through status error bits. The bus word is 1, 2 or 4 bytes wide, set by a parameter. Bus addresses are byte addresses. Read data appears one cycle after the read strobe.

Top module: `nor_cmd_front`

## Requirements
- R1: Synchronous reset clears the status register, the pending command and the second-cycle flag, drives `rdata` to 0, and leaves every array word erased, so array reads return all ones.
- R2: `rdata` changes only on the clock edge that samples `rd_en` high, and holds its value in every cycle without a read.
- R3: With no command armed, the low byte 0x10 or 0x40 arms a program. The next write stores its whole word at word `addr >> log2(DATA_BYTES)`, sets status bit 7 and returns to array reads.
- R4: Command 0x20 immediately erases the sector that contains `addr`, whose base is `addr` rounded down to a multiple of `SECTOR_BYTES`. All its words then read as all ones, other sectors are unchanged, and status bit 7 is set. The following write 0xD0 finishes with status reads; 0xFF or any other value returns to array reads.
- R5: While `read_only` is 1, an erase sets status bit 5 and a program data write sets status bit 4, in place of changing the array. Bit 7 is still set.
- R6: Command 0x50 sets the whole status register to 0 and selects array reads. Commands 0x00 and 0xFF, and any byte that is not a command, select array reads and leave the status unchanged. No command other than 0x50 clears a status bit.
- R7: After 0x70, while an erase or lock is pending or has been confirmed, and while a program is armed, a read returns the status register zero-extended to the bus width.
- R8: After 0x90, the index is `addr[7:0] >> log2(DATA_BYTES)`. Index 0 returns `MFR_ID`, index 1 returns `DEV_ID`, and every other index returns 0.
- R9: After 0x98, a read returns the query byte at that same index, and an index of `QUERY_LEN` or more returns 0. Query mode contains: ASCII "QRY" at 0x10-0x12, 0x01 at 0x13, 0x31 at 0x15, 0x45/0x55 at 0x1B/0x1C, 0x07 at 0x1F and 0x20, 0x0A at 0x21, 0x04 at 0x23-0x25, `ADDR_W` at 0x27, 0x02 at 0x28, 0x01 at 0x2C, the sector count minus one at 0x2D/0x2E (low byte first), `SECTOR_BYTES` bits 15:8 and 23:16 at 0x2F/0x30, and ASCII "PRI11" at 0x31-0x35. Every other entry is 0. Only a write of 0xFF leaves query mode; other writes are ignored.
- R10: Command 0x60 followed by 0xD0 or 0x01 sets status bit 7 and leaves status reads selected. Any other second byte, 0xFF included, returns to array reads.
- R11: Commands are decoded from `wdata[7:0]` only. The modes entered by 0x70 and 0x90 arm nothing, so the next write is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe, one cycle per access |
| rd_en | input | 1 | Bus read strobe, one cycle per access |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 8*DATA_BYTES | Write data; the command byte is the low byte |
| read_only | input | 1 | Blocks program and erase, which then set error bits |
| rdata | output | 8*DATA_BYTES | Read data, valid from the cycle after `rd_en` |

## Verification
A wrong pending command or a stuck second-cycle flag shows up on the first read that follows. That read returns status where array data was expected, or the reverse, or a write meant as data is decoded as a command, and the difference appears one cycle after the read strobe. A wrong sector mask in the erase path shows up when a neighbouring sector reads back as all ones, or when a word inside the erased sector keeps its old value. Status bits that are set or cleared at the wrong time show up on the next status read, so the stimulus follows every mode change with a read through the bus.

// File: rtl/pfcmd_pkg.sv
package pfcmd_pkg;

  // command byte codes (decoded from the low data byte)
  localparam logic [7:0] OP_RESET0   = 8'h00;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLR_STAT = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_RD_STAT  = 8'h70;
  localparam logic [7:0] OP_RD_ID    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;

  // status register bit positions
  localparam int ST_READY     = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR  = 4;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_IDENT, SRC_QUERY} rd_src_e;

  // which read source a pending command selects
  function automatic rd_src_e src_for_cmd(logic [7:0] c);
    case (c)
      OP_RESET0: return SRC_ARRAY;
      OP_RD_ID:  return SRC_IDENT;
      OP_QUERY:  return SRC_QUERY;
      default:   return SRC_STATUS;
    endcase
  endfunction

  // identifier / query index: low address byte scaled by bus width
  function automatic logic [7:0] table_index(logic [7:0] low, int unsigned shift);
    return low >> shift;
  endfunction

  // identifier word for an index
  function automatic logic [15:0] id_word(logic [7:0] idx, logic [15:0] mfr, logic [15:0] dev);
    if (idx == 8'd0) return mfr;
    if (idx == 8'd1) return dev;
    return 16'h0000;
  endfunction

  // query table content, computed from the geometry
  function automatic logic [7:0] query_byte(logic [7:0] idx, int unsigned addr_w,
                                            int unsigned sectors, int unsigned sector_bytes);
    logic [31:0] ns;
    logic [31:0] sb;
    ns = 32'(sectors) - 32'd1;
    sb = 32'(sector_bytes);
    case (idx)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h15: return 8'h31;
      8'h1B: return 8'h45;
      8'h1C: return 8'h55;
      8'h1F: return 8'h07;
      8'h20: return 8'h07;
      8'h21: return 8'h0A;
      8'h23: return 8'h04;
      8'h24: return 8'h04;
      8'h25: return 8'h04;
      8'h27: return 8'(addr_w);
      8'h28: return 8'h02;
      8'h2C: return 8'h01;
      8'h2D: return ns[7:0];
      8'h2E: return ns[15:8];
      8'h2F: return sb[15:8];
      8'h30: return sb[23:16];
      8'h31: return 8'h50;
      8'h32: return 8'h52;
      8'h33: return 8'h49;
      8'h34: return 8'h31;
      8'h35: return 8'h31;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pfcmd_ctrl.sv
module pfcmd_ctrl
  import pfcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wbyte,
  input  logic       read_only,
  output logic [7:0] cmd_q,
  output logic       arm_q,
  output logic [7:0] status_q,
  output logic       prog_fire,
  output logic       erase_fire
);

  logic [7:0] cmd_d;
  logic [7:0] status_d;
  logic       arm_d;
  logic       prog_req;
  logic       erase_req;
  logic       back_to_array;
  logic       clear_cmd;

  assign clear_cmd = wr_en && !arm_q && (wbyte == OP_CLR_STAT);

  always_comb begin
    cmd_d         = cmd_q;
    arm_d         = arm_q;
    status_d      = status_q;
    prog_req      = 1'b0;
    erase_req     = 1'b0;
    back_to_array = 1'b0;
    if (wr_en) begin
      if (!arm_q) begin
        case (wbyte)
          OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
            cmd_d = wbyte;
            arm_d = 1'b1;
          end
          OP_ERASE: begin
            erase_req          = 1'b1;
            cmd_d              = wbyte;
            arm_d              = 1'b1;
            status_d[ST_READY] = 1'b1;
            if (read_only) status_d[ST_ERASE_ERR] = 1'b1;
          end
          OP_RD_STAT, OP_RD_ID: cmd_d = wbyte;
          OP_CLR_STAT: begin
            status_d      = '0;
            back_to_array = 1'b1;
          end
          default: back_to_array = 1'b1;
        endcase
      end else begin
        case (cmd_q)
          OP_PROG_A, OP_PROG_B: begin
            prog_req           = 1'b1;
            status_d[ST_READY] = 1'b1;
            if (read_only) status_d[ST_PROG_ERR] = 1'b1;
            back_to_array      = 1'b1;
          end
          OP_QUERY: if (wbyte == OP_ARRAY) back_to_array = 1'b1;
          OP_ERASE, OP_LOCK: begin
            if (wbyte == OP_CONFIRM || (cmd_q == OP_LOCK && wbyte == OP_LOCK_ALT)) begin
              arm_d              = 1'b0;
              status_d[ST_READY] = 1'b1;
            end else begin
              back_to_array = 1'b1;
            end
          end
          default: back_to_array = 1'b1;
        endcase
      end
      if (back_to_array) begin
        cmd_d = OP_RESET0;
        arm_d = 1'b0;
      end
    end
  end

  assign prog_fire  = prog_req && !read_only;
  assign erase_fire = erase_req && !read_only;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= OP_RESET0;
      arm_q    <= 1'b0;
      status_q <= '0;
    end else begin
      cmd_q    <= cmd_d;
      arm_q    <= arm_d;
      status_q <= status_d;
    end
  end

  assert_prog_ready_R3: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> (status_q[ST_READY] && cmd_q == OP_RESET0 && !arm_q));

  assert_erase_ready_R4: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> status_q[ST_READY]);

  assert_ro_erase_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (erase_req && read_only) |=> status_q[ST_ERASE_ERR]);

  assert_ro_prog_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (prog_req && read_only) |=> status_q[ST_PROG_ERR]);

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (rst)
    clear_cmd |=> (status_q == 8'h00 && cmd_q == OP_RESET0));

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[ST_READY]) |-> $past(clear_cmd));

  assert_stat_no_arm_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !arm_q && (wbyte == OP_RD_STAT || wbyte == OP_RD_ID)) |=> !arm_q);

endmodule

// File: rtl/pfcmd_array.sv
module pfcmd_array #(
  parameter int DW           = 16,
  parameter int WA_W         = 7,
  parameter int SEC_W        = 3,
  parameter int SECTOR_WORDS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_we,
  input  logic [WA_W-1:0]  prog_addr,
  input  logic [DW-1:0]    prog_data,
  input  logic             erase_go,
  input  logic [SEC_W-1:0] erase_sec,
  input  logic             rd_en,
  input  logic [WA_W-1:0]  rd_addr,
  output logic [DW-1:0]    rd_word
);

  localparam int WORDS = 2 ** WA_W;

  logic [DW-1:0]  mem_q [WORDS];
  logic [WORDS-1:0] written_q;
  logic [WORDS-1:0] erase_hit;
  logic [WORDS-1:0] prog_hit;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    localparam logic [SEC_W-1:0] MY_SEC = SEC_W'(gi / SECTOR_WORDS);
    assign erase_hit[gi] = erase_go && (erase_sec == MY_SEC);
    assign prog_hit[gi]  = prog_we && (prog_addr == WA_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (rst) written_q <= '0;
    else     written_q <= (written_q & ~erase_hit) | prog_hit;
  end

  always_ff @(posedge clk) begin
    if (prog_we) mem_q[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_word <= '0;
    else if (rd_en) rd_word <= written_q[rd_addr] ? mem_q[rd_addr] : '1;
  end

  assert_erase_blank_R4: assert property (@(posedge clk) disable iff (rst)
    erase_go |=> ((written_q & $past(erase_hit)) == '0));

  assert_prog_marks_R3: assert property (@(posedge clk) disable iff (rst)
    prog_we |=> (written_q != '0));

endmodule

// File: rtl/pfcmd_rdsel.sv
module pfcmd_rdsel
  import pfcmd_pkg::*;
#(
  parameter int          DW           = 16,
  parameter int          OFF_W        = 1,
  parameter int          QUERY_LEN    = 82,
  parameter int          ADDR_W       = 8,
  parameter int          SECTORS      = 8,
  parameter int          SECTOR_BYTES = 32,
  parameter logic [15:0] MFR_ID       = 16'h00A5,
  parameter logic [15:0] DEV_ID       = 16'h7C21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [7:0]    cmd_q,
  input  logic [7:0]    status_q,
  input  logic [7:0]    addr_lo,
  input  logic [DW-1:0] array_word,
  output logic [DW-1:0] rdata
);

  localparam logic [8:0] QLEN9 = 9'(QUERY_LEN);

  logic [7:0]    idx;
  rd_src_e       src_d;
  rd_src_e       src_q;
  logic [DW-1:0] side_d;
  logic [DW-1:0] side_q;

  assign idx = table_index(addr_lo, OFF_W);

  always_comb begin
    src_d = src_for_cmd(cmd_q);
    case (src_d)
      SRC_STATUS: side_d = DW'(status_q);
      SRC_IDENT:  side_d = DW'(id_word(idx, MFR_ID, DEV_ID));
      SRC_QUERY:  side_d = ({1'b0, idx} < QLEN9)
                           ? DW'(query_byte(idx, ADDR_W, SECTORS, SECTOR_BYTES)) : '0;
      default:    side_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_STATUS;
      side_q <= '0;
    end else if (rd_en) begin
      src_q  <= src_d;
      side_q <= side_d;
    end
  end

  assign rdata = (src_q == SRC_ARRAY) ? array_word : side_q;

  assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_ident_tail_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cmd_q == OP_RD_ID && idx > 8'd1) |=> (rdata == '0));

  assert_query_range_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cmd_q == OP_QUERY && {1'b0, idx} >= QLEN9) |=> (rdata == '0));

endmodule

// File: rtl/nor_cmd_front.sv
module nor_cmd_front
  import pfcmd_pkg::*;
#(
  parameter int          DATA_BYTES   = 2,
  parameter int          ADDR_W       = 8,
  parameter int          SECTOR_BYTES = 32,
  parameter int          QUERY_LEN    = 82,
  parameter logic [15:0] MFR_ID       = 16'h00A5,
  parameter logic [15:0] DEV_ID       = 16'h7C21
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [8*DATA_BYTES-1:0] wdata,
  input  logic                    read_only,
  output logic [8*DATA_BYTES-1:0] rdata
);

  localparam int DW           = 8 * DATA_BYTES;
  localparam int OFF_W        = $clog2(DATA_BYTES);
  localparam int WA_W         = ADDR_W - OFF_W;
  localparam int SECTOR_WORDS = SECTOR_BYTES / DATA_BYTES;
  localparam int SEC_OFF      = $clog2(SECTOR_BYTES);
  localparam int SECTORS      = (2 ** ADDR_W) / SECTOR_BYTES;
  localparam int SEC_W        = (SECTORS > 1) ? $clog2(SECTORS) : 1;

  logic [7:0]       cmd_q;
  logic             arm_q;
  logic [7:0]       status_q;
  logic             prog_fire;
  logic             erase_fire;
  logic [WA_W-1:0]  word_addr;
  logic [SEC_W-1:0] sector_sel;
  logic [DW-1:0]    array_word;

  assign word_addr = addr[ADDR_W-1:OFF_W];

  if (SECTORS > 1) begin : g_multi_sector
    assign sector_sel = addr[ADDR_W-1:SEC_OFF];
  end else begin : g_one_sector
    assign sector_sel = '0;
  end

  pfcmd_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wbyte      (wdata[7:0]),
    .read_only  (read_only),
    .cmd_q      (cmd_q),
    .arm_q      (arm_q),
    .status_q   (status_q),
    .prog_fire  (prog_fire),
    .erase_fire (erase_fire)
  );

  pfcmd_array #(
    .DW           (DW),
    .WA_W         (WA_W),
    .SEC_W        (SEC_W),
    .SECTOR_WORDS (SECTOR_WORDS)
  ) u_array (
    .clk       (clk),
    .rst       (rst),
    .prog_we   (prog_fire),
    .prog_addr (word_addr),
    .prog_data (wdata),
    .erase_go  (erase_fire),
    .erase_sec (sector_sel),
    .rd_en     (rd_en),
    .rd_addr   (word_addr),
    .rd_word   (array_word)
  );

  pfcmd_rdsel #(
    .DW           (DW),
    .OFF_W        (OFF_W),
    .QUERY_LEN    (QUERY_LEN),
    .ADDR_W       (ADDR_W),
    .SECTORS      (SECTORS),
    .SECTOR_BYTES (SECTOR_BYTES),
    .MFR_ID       (MFR_ID),
    .DEV_ID       (DEV_ID)
  ) u_rdsel (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .cmd_q      (cmd_q),
    .status_q   (status_q),
    .addr_lo    (8'(addr)),
    .array_word (array_word),
    .rdata      (rdata)
  );

  assert_armed_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    arm_q |-> (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B || cmd_q == OP_ERASE ||
               cmd_q == OP_LOCK || cmd_q == OP_QUERY));

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cmd_q == OP_RESET0 && !arm_q && status_q == 8'h00 && rdata == '0));

  assert_ro_no_change_R5: assert property (@(posedge clk) disable iff (rst)
    read_only |-> (!prog_fire && !erase_fire));

endmodule

// File: tb/nor_cmd_front_tb_top.sv
module nor_cmd_front_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int          DB  = 2;
  localparam int          AW  = 8;
  localparam int          SB  = 32;
  localparam int          QL  = 82;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h7C21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        read_only = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;

  always #2.5 clk = ~clk;

  nor_cmd_front #(
    .DATA_BYTES(DB), .ADDR_W(AW), .SECTOR_BYTES(SB), .QUERY_LEN(QL),
    .MFR_ID(MFR), .DEV_ID(DEV)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .read_only(read_only), .rdata(rdata)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    running = 1'b0;
  bit    done = 1'b0;
  string drv_tag = "R1";
  string exp_tag = "R1";

  // behavioural reference: missing key = erased word
  int          m_mem[int];
  logic [7:0]  m_status;
  logic [7:0]  m_cmd;
  bit          m_arm;
  logic [15:0] exp_rd;

  function automatic logic [7:0] qref(int i);
    string tag_a = "QRY";
    string tag_b = "PRI11";
    if (i >= 'h10 && i <= 'h12) return tag_a[i - 'h10];
    if (i >= 'h31 && i <= 'h35) return tag_b[i - 'h31];
    if (i == 'h23 || i == 'h24 || i == 'h25) return 8'h04;
    if (i == 'h1F || i == 'h20) return 8'h07;
    case (i)
      'h2D: return 8'(((1 << AW) / SB) - 1);
      'h2E: return 8'((((1 << AW) / SB) - 1) >> 8);
      'h2F: return 8'(SB >> 8);
      'h30: return 8'(SB >> 16);
      'h27: return 8'(AW);
      'h13, 'h2C: return 8'h01;
      'h15: return 8'h31;
      'h28: return 8'h02;
      'h21: return 8'h0A;
      'h1B: return 8'h45;
      'h1C: return 8'h55;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] mdl_read(int a);
    int w = a / DB;
    int i = (a % 256) / DB;
    if (m_cmd == 8'h00) return m_mem.exists(w) ? 16'(m_mem[w]) : 16'hFFFF;
    if (m_cmd == 8'h90) return (i == 0) ? MFR : ((i == 1) ? DEV : 16'h0000);
    if (m_cmd == 8'h98) return (i < QL) ? {8'h00, qref(i)} : 16'h0000;
    return {8'h00, m_status};
  endfunction

  task automatic mdl_write(int a, logic [15:0] d);
    logic [7:0] c = d[7:0];
    if (!m_arm) begin
      if (c == 8'h10 || c == 8'h40 || c == 8'h60 || c == 8'h98) begin
        m_cmd = c; m_arm = 1'b1;
      end else if (c == 8'h20) begin
        if (read_only) m_status = m_status | 8'h20;
        else for (int k = 0; k < SB / DB; k++) m_mem.delete((a - (a % SB)) / DB + k);
        m_status = m_status | 8'h80;
        m_cmd = c; m_arm = 1'b1;
      end else if (c == 8'h70 || c == 8'h90) begin
        m_cmd = c;
      end else begin
        if (c == 8'h50) m_status = 8'h00;
        m_cmd = 8'h00;
      end
    end else begin
      if (m_cmd == 8'h10 || m_cmd == 8'h40) begin
        if (read_only) m_status = m_status | 8'h10;
        else m_mem[a / DB] = int'(d);
        m_status = m_status | 8'h80;
        m_cmd = 8'h00; m_arm = 1'b0;
      end else if (m_cmd == 8'h98) begin
        if (c == 8'hFF) begin m_cmd = 8'h00; m_arm = 1'b0; end
      end else if (c == 8'hD0 || (m_cmd == 8'h60 && c == 8'h01)) begin
        m_arm = 1'b0; m_status = m_status | 8'h80;
      end else begin
        m_cmd = 8'h00; m_arm = 1'b0;
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mem.delete();
      m_status = 8'h00; m_cmd = 8'h00; m_arm = 1'b0; exp_rd = 16'h0000;
    end else begin
      if (rd_en) begin exp_rd = mdl_read(int'(addr)); exp_tag = drv_tag; end
      if (wr_en) mdl_write(int'(addr), wdata);
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running && !done) begin
      vectors++;
      if (rdata !== exp_rd) begin
        miscompares++;
        $display("FAIL %s: rdata actual=%h expected=%h", exp_tag, rdata, exp_rd);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input string t);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d; drv_tag = t;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string t);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b0; addr = a; drv_tag = t;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    // R1: erased array, zero read data after reset
    idle(2);
    rd(8'h00, "R1"); rd(8'h7E, "R1"); rd(8'hFE, "R1");
    // R2: read data holds across idle cycles
    idle(4);
    // R3: program through both arming codes
    wr(8'h10, 16'h0040, "R3"); rd(8'h10, "R7"); wr(8'h10, 16'h1234, "R3");
    rd(8'h10, "R3"); idle(2);
    wr(8'h52, 16'h0010, "R3"); wr(8'h52, 16'hBEEF, "R3"); rd(8'h52, "R3"); rd(8'h50, "R3");
    // R7: status read after 0x70
    wr(8'h00, 16'h0070, "R7"); rd(8'h00, "R7"); rd(8'h44, "R7");
    // R6: clear status, back to array
    wr(8'h00, 16'h0050, "R6"); rd(8'h10, "R6");
    wr(8'h00, 16'h0070, "R6"); rd(8'h00, "R6");
    wr(8'h00, 16'h0000, "R6"); rd(8'h52, "R6");
    wr(8'h00, 16'h0033, "R6"); rd(8'h10, "R6");
    // R4: fill sectors 1 and 2, erase sector 1 from a mid address
    for (int k = 0; k < 4; k++) begin
      wr(8'(8'h20 + 2 * k), 16'h0040, "R4"); wr(8'(8'h20 + 2 * k), 16'(16'hA000 + k), "R4");
      wr(8'(8'h3E - 2 * k), 16'h0040, "R4"); wr(8'(8'h3E - 2 * k), 16'(16'hB000 + k), "R4");
      wr(8'(8'h40 + 2 * k), 16'h0040, "R4"); wr(8'(8'h40 + 2 * k), 16'(16'hC000 + k), "R4");
    end
    wr(8'h00, 16'h0050, "R4");
    wr(8'h2E, 16'h0020, "R4"); rd(8'h2E, "R4"); wr(8'h2E, 16'h00D0, "R4"); rd(8'h20, "R4");
    wr(8'h00, 16'h00FF, "R4");
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h20 + 2 * k), "R4"); rd(8'(8'h3E - 2 * k), "R4"); rd(8'(8'h40 + 2 * k), "R4");
    end
    rd(8'h10, "R4");
    wr(8'h4A, 16'h0020, "R4"); wr(8'h4A, 16'h00FF, "R4"); rd(8'h40, "R4");
    wr(8'h52, 16'h0020, "R4"); wr(8'h52, 16'h0033, "R4"); rd(8'h52, "R4"); rd(8'h10, "R4");
    // R5: read-only blocks program and erase
    wr(8'h00, 16'h0050, "R5");
    read_only = 1'b1;
    wr(8'h10, 16'h0040, "R5"); wr(8'h10, 16'h5555, "R5"); rd(8'h10, "R5");
    wr(8'h00, 16'h0070, "R5"); rd(8'h00, "R5");
    wr(8'h04, 16'h0020, "R5"); wr(8'h04, 16'h00D0, "R5"); rd(8'h04, "R5");
    wr(8'h00, 16'h00FF, "R5"); rd(8'h10, "R5");
    read_only = 1'b0;
    wr(8'h00, 16'h0050, "R5"); rd(8'h10, "R5");
    // R8: identifier reads, width-scaled index
    wr(8'h00, 16'h0090, "R8");
    rd(8'h00, "R8"); rd(8'h01, "R8"); rd(8'h02, "R8"); rd(8'h04, "R8"); rd(8'hFE, "R8");
    // R11: 0x90 arms nothing; upper byte ignored in decode
    wr(8'h00, 16'hAB70, "R11"); rd(8'h00, "R11");
    wr(8'h00, 16'h1290, "R11"); rd(8'h02, "R11");
    wr(8'h00, 16'h00FF, "R11"); rd(8'h10, "R11");
    // R9: query table, out-of-range index, only 0xFF leaves
    wr(8'h00, 16'h0098, "R9");
    for (int k = 'h10; k <= 'h36; k++) rd(8'(2 * k), "R9");
    rd(8'h00, "R9"); rd(8'hA2, "R9"); rd(8'hA4, "R9"); rd(8'hFE, "R9");
    wr(8'h00, 16'h0070, "R9"); rd(8'h20, "R9");
    wr(8'h00, 16'h0050, "R9"); rd(8'h4E, "R9");
    wr(8'h00, 16'h00FF, "R9"); rd(8'h10, "R9");
    // R10: lock acknowledge and abort paths
    wr(8'h00, 16'h0050, "R10");
    wr(8'h20, 16'h0060, "R10"); wr(8'h20, 16'h00D0, "R10"); rd(8'h20, "R10");
    wr(8'h00, 16'h0050, "R10");
    wr(8'h20, 16'h0060, "R10"); wr(8'h20, 16'h0001, "R10"); rd(8'h40, "R10");
    wr(8'h00, 16'h0050, "R10");
    wr(8'h20, 16'h0060, "R10"); wr(8'h20, 16'h0033, "R10"); rd(8'h40, "R10");
    wr(8'h20, 16'h0060, "R10"); wr(8'h20, 16'h00FF, "R10"); rd(8'h10, "R10");
    wr(8'h00, 16'h0070, "R10"); rd(8'h00, "R10");
    // R1: reset in the middle of a query session
    wr(8'h00, 16'h0098, "R1");
    @(negedge clk); rst = 1'b1; drv_tag = "R1";
    repeat (2) @(negedge clk);
    rst = 1'b0;
    idle(1);
    rd(8'h10, "R1"); rd(8'h52, "R1");
    wr(8'h00, 16'h0070, "R1"); rd(8'h00, "R1");
    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule